// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block sits between a core's byte-wide load/store port and a backing memory that moves whole blocks. It keeps a small direct-mapped array of lines. Each line holds a valid flag, a dirty flag, a tag and one block of bytes. With the default parameters there are four lines of two bytes each, covering a 4-bit byte address space.

A hit is served from the array in the cycle of the request, and no memory traffic results. A miss allocates the line for both loads and stores. The dirty victim is written back first as a complete block. The new block is then fetched, and a store merges its byte into the fetched block and marks the line dirty. Two counters record how many accesses hit and how many missed.

The core raises a request with an address, a write flag and a write byte, and holds them steady until ready is seen. The memory side uses a request/acknowledge handshake, with one block per transaction.

Top module: `byte_cache`

## Requirements
- R1: The byte address is decoded with bit 0 as the byte-in-block offset, bits 2:1 as the line index and bit 3 as the tag. Two addresses that differ only in bit 3 compete for the same line.
- R2: After reset every line is invalid and clean, both counters read zero, core_ready is low and mem_req is low.
- R3: An access whose line is valid and whose stored tag equals the address tag completes in the request cycle. core_ready is high in that cycle, core_rdata carries the addressed byte (for a store, the byte written), and mem_req stays low.
- R4: A load miss to an invalid or clean line spends one lookup cycle with core_ready and mem_req low. It then issues exactly one read transaction for block address {tag, index}. The line becomes valid and clean with the new tag.
- R5: A store miss also allocates. After the fill, the line holds the fetched block with the addressed byte replaced by the write byte, the line is dirty, and memory is not written during the access.
- R6: A miss on a valid dirty line first issues a write transaction (mem_we high) carrying both bytes of the line to block address {old tag, index}. The read transaction for the new block follows in the next cycle.
- R7: A store that hits marks the line dirty and causes no memory transaction. A later eviction of that line writes the stored byte back.
- R8: hit_count increments once per hit and miss_count once per miss, never both in one cycle. Loads to 1 and 8, a store to 4, a store to 13 and then a load from 9 leave them at 1 and 4.
- R9: While mem_req is high and mem_ack is low, mem_req, mem_we and mem_blk_addr hold steady. On a miss, core_ready rises in the cycle after the read acknowledge, with core_rdata valid in that cycle.
- R10: In mem_wblock and mem_rblock, the byte at offset k occupies bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Access request, held until core_ready |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | 4 | Byte address |
| core_wdata | input | 8 | Store byte |
| core_ready | output | 1 | Access completes this cycle |
| core_rdata | output | 8 | Addressed byte, valid with core_ready |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = block writeback, 0 = block fetch |
| mem_blk_addr | output | 3 | Block address {tag, index} |
| mem_wblock | output | 16 | Writeback block data |
| mem_ack | input | 1 | Memory completes the current transaction |
| mem_rblock | input | 16 | Fetched block, valid with mem_ack |
| hit_count | output | 16 | Number of hits |
| miss_count | output | 16 | Number of misses |

## Verification
A hit is due in the same cycle as the request, so the bench drives the request away from the clock edge and samples core_ready and core_rdata before the next edge. A miss spends one lookup cycle with everything quiet. Each memory transaction then lasts acknowledge-latency plus one cycles, and ready follows one cycle after the fill acknowledge. The bench builds that schedule from its own line model and checks the core and memory outputs at every cycle of the access, using memory latencies of zero, one and two cycles. The counters move at the edge that ends the lookup or the hit cycle, so they are compared once the request has been dropped.

// File: rtl/bc_pkg.sv
package bc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2,
      ST_DONE  = 2'd3
   } bc_state_e;
endpackage

// File: rtl/bc_line_store.sv
module bc_line_store #(
   parameter int INDEX_W = 2,
   parameter int TAG_W   = 1,
   parameter int BLK_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] rd_idx,
   output logic               rd_valid,
   output logic               rd_dirty,
   output logic [TAG_W-1:0]   rd_tag,
   output logic [BLK_W-1:0]   rd_block,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_idx,
   input  logic               wr_valid,
   input  logic               wr_dirty,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [BLK_W-1:0]   wr_block
);
   localparam int LINES = 1 << INDEX_W;

   logic [LINES-1:0] valid_vec;
   logic [LINES-1:0] dirty_vec;
   logic [TAG_W-1:0] tag_arr   [LINES];
   logic [BLK_W-1:0] block_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic             v_r;
      logic             d_r;
      logic [TAG_W-1:0] t_r;
      logic [BLK_W-1:0] b_r;
      logic             sel;

      assign sel = wr_en && (wr_idx == INDEX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            d_r <= 1'b0;
            t_r <= '0;
            b_r <= '0;
         end else if (sel) begin
            v_r <= wr_valid;
            d_r <= wr_dirty;
            t_r <= wr_tag;
            b_r <= wr_block;
         end
      end

      assign valid_vec[g] = v_r;
      assign dirty_vec[g] = d_r;
      assign tag_arr[g]   = t_r;
      assign block_arr[g] = b_r;

      // R5
      dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         d_r |-> v_r)
         else $error("dirty line %0d is not valid", g);
   end

   assign rd_valid = valid_vec[rd_idx];
   assign rd_dirty = dirty_vec[rd_idx];
   assign rd_tag   = tag_arr[rd_idx];
   assign rd_block = block_arr[rd_idx];
endmodule

// File: rtl/bc_lane_pick.sv
module bc_lane_pick #(
   parameter int DATA_W   = 8,
   parameter int OFFSET_W = 1
) (
   input  logic [DATA_W*(1<<OFFSET_W)-1:0] blk,
   input  logic [OFFSET_W-1:0]             off,
   output logic [DATA_W-1:0]               byte_out
);
   localparam int BYTES = 1 << OFFSET_W;

   logic [DATA_W-1:0] lanes [BYTES];

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lanes[g] = blk[g*DATA_W +: DATA_W];
   end

   assign byte_out = lanes[off];
endmodule

// File: rtl/bc_lane_merge.sv
module bc_lane_merge #(
   parameter int DATA_W   = 8,
   parameter int OFFSET_W = 1
) (
   input  logic [DATA_W*(1<<OFFSET_W)-1:0] blk_in,
   input  logic [OFFSET_W-1:0]             off,
   input  logic [DATA_W-1:0]               byte_in,
   output logic [DATA_W*(1<<OFFSET_W)-1:0] blk_out
);
   localparam int BYTES = 1 << OFFSET_W;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign blk_out[g*DATA_W +: DATA_W] =
         (off == OFFSET_W'(g)) ? byte_in : blk_in[g*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/bc_counters.sv
module bc_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_pulse,
   input  logic             miss_pulse,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         if (hit_pulse)  hit_count  <= hit_count + CNT_W'(1);
         if (miss_pulse) miss_count <= miss_count + CNT_W'(1);
      end
   end

   // R8
   single_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))))
      else $error("hit and miss counters moved together");
endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
   import bc_pkg::*;
#(
   parameter int INDEX_W = 2,
   parameter int TAG_W   = 1,
   parameter int BLK_W   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     core_req,
   input  logic                     core_we,
   input  logic [TAG_W-1:0]         addr_tag,
   input  logic [INDEX_W-1:0]       addr_idx,
   input  logic                     line_valid,
   input  logic                     line_dirty,
   input  logic [TAG_W-1:0]         line_tag,
   input  logic [BLK_W-1:0]         line_block,
   input  logic [BLK_W-1:0]         merged_block,
   input  logic                     mem_ack,
   input  logic [BLK_W-1:0]         mem_rblock,
   output logic                     core_ready,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [TAG_W+INDEX_W-1:0] mem_blk_addr,
   output logic [BLK_W-1:0]         mem_wblock,
   output logic                     line_wr_en,
   output logic                     line_wr_valid,
   output logic                     line_wr_dirty,
   output logic [TAG_W-1:0]         line_wr_tag,
   output logic [BLK_W-1:0]         line_wr_block,
   output logic                     merge_from_mem,
   output logic                     hit_pulse,
   output logic                     miss_pulse
);
   bc_state_e st_q, st_d;
   logic      hit;

   assign hit        = line_valid && (line_tag == addr_tag);
   assign mem_wblock = line_block;

   always_comb begin
      st_d           = st_q;
      core_ready     = 1'b0;
      mem_req        = 1'b0;
      mem_we         = 1'b0;
      mem_blk_addr   = {addr_tag, addr_idx};
      line_wr_en     = 1'b0;
      line_wr_valid  = 1'b1;
      line_wr_dirty  = 1'b0;
      line_wr_tag    = addr_tag;
      line_wr_block  = merged_block;
      merge_from_mem = 1'b0;
      hit_pulse      = 1'b0;
      miss_pulse     = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (core_req) begin
               if (hit) begin
                  core_ready = 1'b1;
                  hit_pulse  = 1'b1;
                  if (core_we) begin
                     line_wr_en    = 1'b1;
                     line_wr_dirty = 1'b1;
                  end
               end else begin
                  miss_pulse = 1'b1;
                  st_d = (line_valid && line_dirty) ? ST_WBACK : ST_FILL;
               end
            end
         end
         ST_WBACK: begin
            mem_req      = 1'b1;
            mem_we       = 1'b1;
            mem_blk_addr = {line_tag, addr_idx};
            if (mem_ack) st_d = ST_FILL;
         end
         ST_FILL: begin
            mem_req        = 1'b1;
            merge_from_mem = 1'b1;
            if (mem_ack) begin
               line_wr_en    = 1'b1;
               line_wr_dirty = core_we;
               line_wr_block = core_we ? merged_block : mem_rblock;
               st_d          = ST_DONE;
            end
         end
         ST_DONE: begin
            core_ready = 1'b1;
            st_d       = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_blk_addr)))
      else $error("memory request changed before acknowledge");

   // R6
   wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we))
      else $error("writeback not followed by fill");

   // R3
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_ready |-> core_req)
      else $error("ready without request");

   // R3
   ready_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_ready |-> !mem_req)
      else $error("ready while memory busy");

   // R9
   ready_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> core_ready)
      else $error("ready did not follow fill acknowledge");
endmodule

// File: rtl/byte_cache.sv
module byte_cache #(
   parameter int ADDR_W   = 4,
   parameter int INDEX_W  = 2,
   parameter int OFFSET_W = 1,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              core_req,
   input  logic                              core_we,
   input  logic [ADDR_W-1:0]                 core_addr,
   input  logic [DATA_W-1:0]                 core_wdata,
   output logic                              core_ready,
   output logic [DATA_W-1:0]                 core_rdata,
   output logic                              mem_req,
   output logic                              mem_we,
   output logic [ADDR_W-OFFSET_W-1:0]        mem_blk_addr,
   output logic [DATA_W*(1<<OFFSET_W)-1:0]   mem_wblock,
   input  logic                              mem_ack,
   input  logic [DATA_W*(1<<OFFSET_W)-1:0]   mem_rblock,
   output logic [CNT_W-1:0]                  hit_count,
   output logic [CNT_W-1:0]                  miss_count
);
   localparam int TAG_W = ADDR_W - INDEX_W - OFFSET_W;
   localparam int BLK_W = DATA_W * (1 << OFFSET_W);

   initial begin
      assert (TAG_W >= 1) else $fatal(1, "address too narrow for index and offset");
      assert (OFFSET_W >= 1) else $fatal(1, "block must hold at least two bytes");
      assert (INDEX_W >= 1) else $fatal(1, "at least two lines required");
      assert (DATA_W >= 1 && CNT_W >= 1) else $fatal(1, "bad width");
   end

   // R1: address fields
   logic [OFFSET_W-1:0] a_off;
   logic [INDEX_W-1:0]  a_idx;
   logic [TAG_W-1:0]    a_tag;
   assign a_off = core_addr[OFFSET_W-1:0];
   assign a_idx = core_addr[OFFSET_W +: INDEX_W];
   assign a_tag = core_addr[ADDR_W-1 -: TAG_W];

   logic             l_valid, l_dirty;
   logic [TAG_W-1:0] l_tag;
   logic [BLK_W-1:0] l_block;
   logic             w_en, w_valid, w_dirty;
   logic [TAG_W-1:0] w_tag;
   logic [BLK_W-1:0] w_block;
   logic [BLK_W-1:0] merge_src, merged;
   logic             from_mem;
   logic             hit_p, miss_p;
   logic [DATA_W-1:0] line_byte;

   bc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_idx(a_idx),
      .rd_valid(l_valid), .rd_dirty(l_dirty), .rd_tag(l_tag), .rd_block(l_block),
      .wr_en(w_en), .wr_idx(a_idx), .wr_valid(w_valid), .wr_dirty(w_dirty),
      .wr_tag(w_tag), .wr_block(w_block)
   );

   assign merge_src = from_mem ? mem_rblock : l_block;

   bc_lane_merge #(.DATA_W(DATA_W), .OFFSET_W(OFFSET_W)) u_merge (
      .blk_in(merge_src), .off(a_off), .byte_in(core_wdata), .blk_out(merged)
   );

   bc_lane_pick #(.DATA_W(DATA_W), .OFFSET_W(OFFSET_W)) u_pick (
      .blk(l_block), .off(a_off), .byte_out(line_byte)
   );

   assign core_rdata = core_we ? core_wdata : line_byte;

   bc_ctrl #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
      .addr_tag(a_tag), .addr_idx(a_idx),
      .line_valid(l_valid), .line_dirty(l_dirty), .line_tag(l_tag), .line_block(l_block),
      .merged_block(merged), .mem_ack(mem_ack), .mem_rblock(mem_rblock),
      .core_ready(core_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_blk_addr(mem_blk_addr), .mem_wblock(mem_wblock),
      .line_wr_en(w_en), .line_wr_valid(w_valid), .line_wr_dirty(w_dirty),
      .line_wr_tag(w_tag), .line_wr_block(w_block), .merge_from_mem(from_mem),
      .hit_pulse(hit_p), .miss_pulse(miss_p)
   );

   bc_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit_pulse(hit_p), .miss_pulse(miss_p),
      .hit_count(hit_count), .miss_count(miss_count)
   );
endmodule

// File: tb/test_byte_cache.sv
module test_byte_cache;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_req = 1'b0, core_we = 1'b0;
   logic [3:0]  core_addr = '0;
   logic [7:0]  core_wdata = '0;
   logic        core_ready;
   logic [7:0]  core_rdata;
   logic        mem_req, mem_we;
   logic [2:0]  mem_blk_addr;
   logic [15:0] mem_wblock;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rblock = '0;
   logic [15:0] hit_count, miss_count;

   int checks = 0;
   int fails  = 0;

   // behavioural reference state
   int bmem [16];
   bit ref_v [4];
   bit ref_d [4];
   int ref_t [4];
   int ref_b [4][2];
   int ref_hits = 0;
   int ref_misses = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_cache i_byte_cache (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
      .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
      .core_rdata(core_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_blk_addr(mem_blk_addr), .mem_wblock(mem_wblock), .mem_ack(mem_ack),
      .mem_rblock(mem_rblock), .hit_count(hit_count), .miss_count(miss_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // one memory transaction, entered and left just after a falling edge
   task automatic mem_phase(input bit wr, input int baddr, input int lat, input string req);
      for (int k = 0; k <= lat; k++) begin
         chk(req, core_ready, 0);
         chk(req, mem_req, 1);
         chk(req, mem_we, wr);
         chk(req, mem_blk_addr, baddr);
         if (wr) begin
            // R10: offset k at bits [8k+7:8k]
            chk("R10", mem_wblock[7:0],  bmem_wb_lo);
            chk("R10", mem_wblock[15:8], bmem_wb_hi);
         end
         if (k == lat) begin
            mem_ack = 1'b1;
            if (wr) begin
               bmem[baddr*2]   = bmem_wb_lo;
               bmem[baddr*2+1] = bmem_wb_hi;
            end else begin
               mem_rblock = {bmem[baddr*2+1][7:0], bmem[baddr*2][7:0]};
            end
         end
         @(posedge clk);
         @(negedge clk);
         mem_ack = 1'b0;
         #1;
      end
   endtask

   int bmem_wb_lo, bmem_wb_hi;

   task automatic access(input bit wr, input int a, input int wd, input int lat);
      int idx, tg, off, exp_byte;
      bit hit;
      idx = (a >> 1) & 3;
      tg  = (a >> 3) & 1;
      off = a & 1;
      hit = ref_v[idx] && (ref_t[idx] == tg);
      core_req = 1'b1; core_we = wr; core_addr = 4'(a); core_wdata = 8'(wd);
      #1;
      if (hit) begin
         exp_byte = wr ? (wd & 255) : ref_b[idx][off];
         chk("R3", core_ready, 1);
         chk("R3", core_rdata, exp_byte);
         chk(wr ? "R7" : "R3", mem_req, 0);
         if (wr) begin ref_b[idx][off] = wd & 255; ref_d[idx] = 1; end
         ref_hits++;
         @(posedge clk); @(negedge clk);
      end else begin
         chk("R4", core_ready, 0);
         chk("R4", mem_req, 0);
         ref_misses++;
         @(posedge clk); @(negedge clk); #1;
         if (ref_v[idx] && ref_d[idx]) begin
            bmem_wb_lo = ref_b[idx][0];
            bmem_wb_hi = ref_b[idx][1];
            mem_phase(1'b1, ref_t[idx]*4 + idx, lat, "R6");
         end
         mem_phase(1'b0, tg*4 + idx, lat, wr ? "R5" : "R4");
         ref_b[idx][0] = bmem[(tg*4+idx)*2];
         ref_b[idx][1] = bmem[(tg*4+idx)*2+1];
         if (wr) ref_b[idx][off] = wd & 255;
         ref_v[idx] = 1; ref_d[idx] = wr; ref_t[idx] = tg;
         exp_byte = ref_b[idx][off];
         chk("R9", core_ready, 1);
         chk("R9", core_rdata, exp_byte);
         chk("R9", mem_req, 0);
         @(posedge clk); @(negedge clk);
      end
      core_req = 1'b0;
      #1;
      chk("R8", hit_count, ref_hits);
      chk("R8", miss_count, ref_misses);
      chk("R3", core_ready, 0);
      chk("R4", mem_req, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int i = 0; i < 16; i++) bmem[i] = (i * 37 + 11) & 255;
      for (int i = 0; i < 4; i++) begin
         ref_v[i] = 0; ref_d[i] = 0; ref_t[i] = 0; ref_b[i][0] = 0; ref_b[i][1] = 0;
      end
      repeat (3) @(negedge clk);
      #1;
      // R2: reset state
      chk("R2", core_ready, 0);
      chk("R2", mem_req, 0);
      chk("R2", hit_count, 0);
      chk("R2", miss_count, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R2", hit_count, 0);

      // R8: reference trace, 1 hit and 4 misses
      access(0, 1, 0, 0);
      access(0, 8, 0, 1);
      access(1, 4, 18, 2);
      access(1, 13, 29, 1);   // R6: evicts dirty block of address 4
      access(0, 9, 0, 0);
      chk("R8", hit_count, 1);
      chk("R8", miss_count, 4);

      // R1: same index, other tag conflicts; R7: store hit then eviction
      access(1, 9, 77, 0);    // R7 store hit
      access(0, 8, 0, 0);     // hit, other offset
      access(0, 0, 0, 2);     // R6 writeback of 77 then fill
      access(0, 9, 0, 1);     // R1 reload returns 77 from memory
      access(0, 5, 0, 0);     // R6 writeback of store-miss data 29
      access(0, 13, 0, 2);    // value 29 back from memory

      // mixed pattern over all lines and latencies
      for (int i = 0; i < 48; i++) begin
         access((i % 3) == 0, (i * 7 + 3) % 16, (i * 11 + 5) & 255, i % 3);
      end
      summary();
   end
endmodule